// File: doc/BRIEF.md
# Pulse-Swallow Up/Down Channel Counter

This block drives the modulus-control line of a divide-by-8/9 prescaler in an integer-N synthesizer loop. It runs on the prescaler output clock and reads a 5-bit channel code. It repeats a 32-clock period.

- It counts upward from zero until the count equals the code.
- It spends one turnaround clock with an active-low strobe asserted.
- It reloads to 28 and counts downward until the count meets the code again.
- It spends a second turnaround clock, then clears to zero.

The direction flag doubles as the modulus-control output. The preload is 28 rather than 32 for two reasons: each direction change uses up a clock, and the code value is visited once on the way up and once on the way down.

The block has no streaming data path, so every pin is a plain level signal with no valid/ready handshake. The channel code is sampled only when an upward phase begins. A code above 28 cannot give a 32-clock period, so the block raises an error flag and parks the count at zero until a legal code is presented.

Top module: `swallow_ctr`

## Requirements
- R1: A synchronous active-high reset gives count 0, direction up (`ud_o`=0), strobe inactive (`rl_n_o`=1), and it samples `chan_i`; with a legal code `err_o` is 0 after reset.
- R2: While counting up (`ud_o`=0, `rl_n_o`=1), the count rises by one each clock, from 0 to the sampled code C.
- R3: In the clock after the count equals C in the upward phase, `rl_n_o` is 0 for exactly one clock. The count holds at C and `ud_o` stays 0 during that clock. This strobe occurs at cycle index C+1 of the period.
- R4: After the upward turnaround the count is 28 and `ud_o` is 1. The count then falls by one each clock until it equals C.
- R5: In the clock after the count equals C in the downward phase, `rl_n_o` is 0 for one clock with the count at C. The next clock shows count 0 and `ud_o`=0.
- R6: `ud_o` changes exactly at the clock edge that ends each strobe clock, and at no other time outside reset.
- R7: For every legal code C from 0 to 28, the period is 32 clocks: C+1 up clocks, one turnaround, 29−C down clocks and one turnaround. The state after 32 clocks equals the state at cycle 0.
- R8: `chan_i` is sampled only at reset, while in error, and at the edge that ends the downward turnaround. A change at any other time does not alter the current period.
- R9: If the sampled code exceeds 28, `err_o` is 1, the count stays 0, `ud_o` stays 0 and `rl_n_o` stays 1. `chan_i` is resampled every clock while in this state. Once a legal code is sampled, `err_o` is 0 and counting starts from 0 in the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output clock |
| rst | input | 1 | Synchronous reset, active high |
| chan_i | input | 5 | Channel code C |
| cnt_o | output | 5 | Current count value |
| ud_o | output | 1 | Direction / modulus control: 0 = up, 1 = down |
| rl_n_o | output | 1 | Active-low one-clock turnaround strobe |
| err_o | output | 1 | Sampled channel code is above the preload |

## Verification
The bench builds the block with its default width of 5 bits and preload of 28.

- These defaults make the 5-bit code space reach past the legal range, so the illegal codes 29 to 31 can be applied.
- They also let the bench drive both extreme legal codes. With code 0 the upward phase is a single clock. With code 28 the downward phase is a single clock.
- With these values the full 32-clock period is short enough to compare clock by clock for every tabled code.

// File: rtl/swallow_pkg.sv
package swallow_pkg;
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_e;
endpackage

// File: rtl/swallow_match.sv
module swallow_match #(
  parameter int W = 5
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         eq_o
);
  logic [W-1:0] diff;
  assign diff = a_i ^ b_i;
  assign eq_o = ~|diff;
endmodule

// File: rtl/swallow_dir.sv
module swallow_dir
  import swallow_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic flip_i,
  output dir_e dir_o
);
  always_ff @(posedge clk) begin
    if (rst)         dir_o <= DIR_UP;
    else if (flip_i) dir_o <= (dir_o == DIR_UP) ? DIR_DOWN : DIR_UP;
  end

  AST_DIR_FLIPS: assert property (@(posedge clk) disable iff (rst)
    flip_i |=> (dir_o != $past(dir_o)));  // R6
  AST_DIR_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !flip_i |=> $stable(dir_o));  // R6
endmodule

// File: rtl/swallow_count.sv
module swallow_count
  import swallow_pkg::*;
#(
  parameter int W       = 5,
  parameter int PRELOAD = 28
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         zero_i,
  input  logic         load_i,
  input  logic         step_i,
  input  dir_e         dir_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] LOAD_VAL = W'(PRELOAD);
  localparam logic [W-1:0] ONE      = W'(1);

  logic [W-1:0] nxt;
  logic [W-1:0] tgl;

  always_comb begin
    nxt = cnt_o;
    if (zero_i)      nxt = '0;
    else if (load_i) nxt = LOAD_VAL;
    else if (step_i) nxt = (dir_i == DIR_UP) ? cnt_o + ONE : cnt_o - ONE;
  end

  assign tgl = cnt_o ^ nxt;

  for (genvar i = 0; i < W; i++) begin : g_tbit
    always_ff @(posedge clk) begin
      if (rst) cnt_o[i] <= 1'b0;
      else     cnt_o[i] <= cnt_o[i] ^ tgl[i];
    end
  end

  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (rst)
    (load_i && !zero_i) |=> (cnt_o == LOAD_VAL));  // R4
  AST_STEP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!zero_i && !load_i && !step_i) |=> $stable(cnt_o));  // R3
endmodule

// File: rtl/swallow_ctr.sv
module swallow_ctr
  import swallow_pkg::*;
#(
  parameter int CNT_W   = 5,
  parameter int PRELOAD = 28
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] chan_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ud_o,
  output logic             rl_n_o,
  output logic             err_o
);
  localparam logic [CNT_W-1:0] MAX_CODE = CNT_W'(PRELOAD);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  logic [CNT_W-1:0] code_q;
  logic [CNT_W-1:0] cnt;
  logic             turn_q;
  logic             hit;
  logic             bad_code;
  logic             zero_en;
  logic             load_en;
  logic             step_en;
  logic             take_code;
  dir_e             dir;

  assign bad_code  = code_q > MAX_CODE;
  assign load_en   = turn_q && (dir == DIR_UP);
  assign zero_en   = bad_code || (turn_q && (dir == DIR_DOWN));
  assign step_en   = !turn_q && !hit && !bad_code;
  assign take_code = bad_code || (turn_q && (dir == DIR_DOWN));

  swallow_match #(.W(CNT_W)) u_match (
    .a_i (cnt),
    .b_i (code_q),
    .eq_o(hit)
  );

  swallow_count #(.W(CNT_W), .PRELOAD(PRELOAD)) u_count (
    .clk   (clk),
    .rst   (rst),
    .zero_i(zero_en),
    .load_i(load_en),
    .step_i(step_en),
    .dir_i (dir),
    .cnt_o (cnt)
  );

  swallow_dir u_dir (
    .clk   (clk),
    .rst   (rst),
    .flip_i(turn_q),
    .dir_o (dir)
  );

  always_ff @(posedge clk) begin
    if (rst)            code_q <= chan_i;
    else if (take_code) code_q <= chan_i;
  end

  always_ff @(posedge clk) begin
    if (rst)           turn_q <= 1'b0;
    else if (bad_code) turn_q <= 1'b0;
    else if (turn_q)   turn_q <= 1'b0;
    else               turn_q <= hit;
  end

  assign cnt_o  = cnt;
  assign ud_o   = (dir == DIR_DOWN);
  assign rl_n_o = ~turn_q;
  assign err_o  = bad_code;

  AST_UP_STEP: assert property (@(posedge clk) disable iff (rst)
    (!err_o && rl_n_o && !ud_o && cnt_o != code_q) |=> (cnt_o == $past(cnt_o) + ONE));  // R2
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    !rl_n_o |=> rl_n_o);  // R3
  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (rst)
    (!err_o && rl_n_o && ud_o && cnt_o != code_q) |=> (cnt_o == $past(cnt_o) - ONE));  // R4
  AST_TURN_TO_DOWN: assert property (@(posedge clk) disable iff (rst)
    (!rl_n_o && !ud_o) |=> (ud_o && cnt_o == MAX_CODE));  // R4
  AST_TURN_TO_UP: assert property (@(posedge clk) disable iff (rst)
    (!rl_n_o && ud_o) |=> (!ud_o && cnt_o == '0));  // R5
  AST_CODE_KEPT: assert property (@(posedge clk) disable iff (rst)
    (!err_o && !(!rl_n_o && ud_o)) |=> $stable(code_q));  // R8
  AST_ERR_PARKED: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (cnt_o == '0 && !ud_o && rl_n_o));  // R9
endmodule

// File: tb/swallow_ctr_tb.sv
module swallow_ctr_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] chan = 5'd0;
  logic [4:0] cnt;
  logic       ud, rl_n, err;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  swallow_ctr u_dut (
    .clk(clk), .rst(rst), .chan_i(chan),
    .cnt_o(cnt), .ud_o(ud), .rl_n_o(rl_n), .err_o(err)
  );

  // vector: {code[4:0], first strobe index[5:0]}
  localparam logic [10:0] VEC [7] = '{
    {5'd0, 6'd1}, {5'd1, 6'd2}, {5'd6, 6'd7}, {5'd7, 6'd8},
    {5'd14, 6'd15}, {5'd27, 6'd28}, {5'd28, 6'd29}
  };

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [7:0] obs();
    return {cnt, ud, rl_n, err};
  endfunction

  // {cnt, ud, rl_n, err} expected at cycle k of a period with code c
  function automatic logic [7:0] expv(int c, int k);
    if (k <= c)           return {5'(k), 1'b0, 1'b1, 1'b0};
    else if (k == c + 1)  return {5'(c), 1'b0, 1'b0, 1'b0};
    else if (k <= 30)     return {5'(28 - (k - c - 2)), 1'b1, 1'b1, 1'b0};
    else                  return {5'(c), 1'b1, 1'b0, 1'b0};
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(logic [4:0] code, logic exp_err);
    chan = code;
    rst  = 1'b1;
    tick();
    check("R1 reset state", obs(), {5'd0, 1'b0, 1'b1, exp_err});
    rst = 1'b0;
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    // table walk: R2 R3 R4 R5 R7
    foreach (VEC[v]) begin
      int c;
      int first;
      c = int'(VEC[v][10:6]);
      first = -1;
      do_reset(VEC[v][10:6], 1'b0);
      for (int k = 0; k < 32; k++) begin
        check("R2/R4/R5 period trace", obs(), expv(c, k));
        if (!rl_n && first < 0) first = k;
        tick();
      end
      check("R3 first strobe index", 8'(first), 8'(VEC[v][5:0]));
      check("R7 period wrap", obs(), expv(c, 0));
    end

    // R6: direction changes only at the strobe edges
    do_reset(5'd9, 1'b0);
    for (int k = 0; k < 32; k++) begin
      logic u0;
      u0 = ud;
      tick();
      if (k == 10 || k == 31)
        check("R6 ud flips after strobe", {7'd0, ud}, {7'd0, ~u0});
      else
        check("R6 ud steady", {7'd0, ud}, {7'd0, u0});
    end

    // R8: a mid-period change is ignored until the next up phase
    do_reset(5'd3, 1'b0);
    for (int k = 0; k < 32; k++) begin
      if (k == 10) chan = 5'd20;
      check("R8 old code kept", obs(), expv(3, k));
      tick();
    end
    for (int k = 0; k < 32; k++) begin
      check("R8 new code used", obs(), expv(20, k));
      tick();
    end

    // R9: illegal code parks the counter
    do_reset(5'd30, 1'b1);
    for (int k = 0; k < 3; k++) begin
      tick();
      check("R9 parked", obs(), {5'd0, 1'b0, 1'b1, 1'b1});
    end
    chan = 5'd5;
    tick();
    check("R9 recover", obs(), {5'd0, 1'b0, 1'b1, 1'b0});
    tick();
    check("R9 count resumes", obs(), {5'd1, 1'b0, 1'b1, 1'b0});

    // R9: illegal code picked up at the end of a period
    do_reset(5'd2, 1'b0);
    chan = 5'd31;
    for (int k = 0; k < 32; k++) tick();
    check("R9 illegal at period start", obs(), {5'd0, 1'b0, 1'b1, 1'b1});
    chan = 5'd2;
    tick();
    check("R9 legal again", obs(), expv(2, 0));

    // R1: reset in the middle of the down phase
    do_reset(5'd10, 1'b0);
    for (int k = 0; k < 15; k++) tick();
    check("R1 pre-reset down phase", obs(), expv(10, 15));
    do_reset(5'd4, 1'b0);
    tick();
    check("R1 restart after reset", obs(), expv(4, 1));

    summary();
  end
endmodule